// File: doc/BRIEF.md
# Phase-Shedding Power-State Sequencer

This block is the digital sequencer of a multiphase buck regulator with up to four phases. It accepts captured 8-bit command words, each with a valid strobe. The top bit of a word is an active-low request for power saving. The lower seven bits give the voltage code. Power saving turns off the extra phases one at a time until only the two base phases remain. Leaving power saving turns them back on one at a time, in the opposite order. A phase moves in or out of tri-state only at a rising edge of its own PWM signal.

The voltage target does not jump to a new code. It moves one code for each step tick until it reaches the commanded code. Suppose a command changes the code while power saving is requested, and power saving is already in effect. The block then restores every extra phase first, steps the voltage next, and sheds the phases again last. A configuration input sets how many phases are populated; phases that are not populated stay off and the sequence skips them. A command that arrives while a sequence is still running is held and carried out once the sequence ends. Only the latest such command is kept.

Top module: `phase_shed_seq`

## Requirements
- R1: In a command word, bit 7 is the power-saving request (0 = enter power saving, 1 = normal operation) and bits 6:0 are the voltage code.
- R2: Phases 1 and 2 (index 0 and 1) always have `phaseEn`=1 and `phaseTri`=0. On entry to power saving, phase 4 (index 3) is shed before phase 3 (index 2). Phase 3 is shed only after phase 4 has reached tri-state, and at most one phase is between states at any time.
- R3: A shed phase drops `phaseEn` at once. Its `phaseTri` bit goes to 1 at the first PWM rising edge after the drop. A PWM edge in the same clock cycle as the drop does not count, and `phaseTri` changes only at a PWM rising edge of that phase.
- R4: On exit from power saving, phase 3 (index 2) is restored before phase 4 (index 3). A restored phase raises `phaseEn` at once and clears `phaseTri` at its next PWM rising edge.
- R5: A command with bit 7 = 0 and a new code, received while power saving is in effect, first restores all populated phases, then steps the target, then sheds again. The target never moves while a populated phase is off or in tri-state.
- R6: `vidTarget` moves by exactly one code per clock cycle in which `stepTick` is high, toward the commanded code, and does not move without a tick. `targetDone` is 1 when `vidTarget` equals the commanded code.
- R7: `outOff` is 1 when `vidTarget` is 124 or higher. Otherwise `targetTenthMv` is 15500 − 125 × `vidTarget` (in 0.1 mV units), and it is 0 while `outOff` is 1.
- R8: `populated` sets the number of populated phases (values below 2 count as 2). A phase whose index is at or above that count shows `phaseEn`=0 and `phaseTri`=1, and the sequence skips it.
- R9: A command received during a running sequence is held and carried out after the sequence ends. A later command received while one is held replaces it.
- R10: After reset, `vidTarget` and the commanded code are both 127, power saving is not in effect, and every populated phase is enabled and out of tri-state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | One-cycle strobe: `cmdData` holds a new command |
| cmdData | input | 8 | Command word: bit 7 power-saving request (active low), bits 6:0 voltage code |
| populated | input | 3 | Number of populated phases (2 to 4) |
| pwmIn | input | 4 | PWM signal of each phase; its rising edges time tri-state changes |
| stepTick | input | 1 | Voltage step tick |
| phaseEn | output | 4 | Per-phase enable request |
| phaseTri | output | 4 | Per-phase tri-state control (1 = driver tri-stated) |
| vidTarget | output | 7 | Current stepped voltage code |
| targetDone | output | 1 | Target equals the commanded code |
| outOff | output | 1 | Current code means output off |
| targetTenthMv | output | 14 | Target level in 0.1 mV units |

## Verification
Two events can fall in the same clock cycle: a phase's enable drop and a rising edge of that phase's own PWM. The design must not treat that edge as the tri-state moment; it has to wait for the next rising edge. The bench runs every PWM as a square wave with a two-cycle period. It starts the shed at both PWM parities, so in one of the two runs the edge falls in the same cycle as the enable drop. At every enable drop the bench confirms that tri-state is still clear, and it confirms that tri-state changes only at a rising edge that the bench itself generated. It also counts how many times the coincidence happened and requires at least one.

// File: rtl/phase_shed_pkg.sv
package phase_shed_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RESTORE,
    S_STEP,
    S_SHED
  } seqState_t;

  typedef struct packed {
    logic             shed;
    logic             restore;
    logic [SEL_W-1:0] sel;
    logic             stepUp;
    logic             stepDn;
    logic             loadGoal;
  } ctlStrobe_t;
endpackage

// File: rtl/phase_shed_dp.sv
module phase_shed_dp
  import phase_shed_pkg::*;
#(
  parameter int NUM_PHASES  = 4,
  parameter int BASE_PHASES = 2,
  parameter int VID_W       = 7,
  parameter int RESET_CODE  = 127,
  parameter int OFF_CODE    = 124,
  parameter int BASE_TENTH  = 15500,
  parameter int STEP_TENTH  = 125,
  parameter int LEVEL_W     = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            ctl,
  input  logic [VID_W-1:0]      goalIn,
  input  logic [NUM_PHASES-1:0] popMask,
  input  logic [NUM_PHASES-1:0] pwmIn,
  output logic [NUM_PHASES-1:0] phaseEn,
  output logic [NUM_PHASES-1:0] phaseTri,
  output logic [VID_W-1:0]      vidTarget,
  output logic [VID_W-1:0]      goalCode,
  output logic                  outOff,
  output logic [LEVEL_W-1:0]    targetTenthMv
);
  logic [NUM_PHASES-1:0] enReg, triReg, pwmPrev, rise;

  assign rise = pwmIn & ~pwmPrev;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pwmPrev <= '0;
    else       pwmPrev <= pwmIn;

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
    if (i < BASE_PHASES) begin : g_base
      assign enReg[i]  = 1'b1;
      assign triReg[i] = 1'b0;
    end else begin : g_extra
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enReg[i]  <= 1'b1;
          triReg[i] <= 1'b0;
        end else begin
          if (ctl.shed && ctl.sel == SEL_W'(i))         enReg[i] <= 1'b0;
          else if (ctl.restore && ctl.sel == SEL_W'(i)) enReg[i] <= 1'b1;
          if (rise[i]) triReg[i] <= ~enReg[i];
        end
      end

      // R3: tri-state moves only on a PWM rising edge of this phase
      p_tri_on_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
        !$stable(triReg[i]) |-> $past(rise[i]));
      // R3: an edge coinciding with the enable drop does not tri-state the phase
      p_no_instant_tri_r3: assert property (@(posedge clk) disable iff (!rstN)
        $fell(enReg[i]) |-> !triReg[i]);
    end
  end

  assign phaseEn  = enReg & popMask;
  assign phaseTri = triReg | ~popMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidTarget <= VID_W'(RESET_CODE);
      goalCode  <= VID_W'(RESET_CODE);
    end else begin
      if (ctl.loadGoal) goalCode <= goalIn;
      if (ctl.stepUp)      vidTarget <= vidTarget + VID_W'(1);
      else if (ctl.stepDn) vidTarget <= vidTarget - VID_W'(1);
    end
  end

  always_comb begin
    int level;
    outOff = (int'(vidTarget) >= OFF_CODE);
    level  = BASE_TENTH - STEP_TENTH * int'(vidTarget);
    targetTenthMv = outOff ? '0 : LEVEL_W'(level);
  end

  // R6: the target moves by exactly one code per step
  p_step_unit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vidTarget) |->
      (vidTarget == $past(vidTarget) + VID_W'(1)) || (vidTarget == $past(vidTarget) - VID_W'(1)));
endmodule

// File: rtl/phase_shed_ctl.sv
module phase_shed_ctl
  import phase_shed_pkg::*;
#(
  parameter int NUM_PHASES  = 4,
  parameter int BASE_PHASES = 2,
  parameter int VID_W       = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [VID_W:0]        cmdData,
  input  logic                  stepTick,
  input  logic [NUM_PHASES-1:0] popMask,
  input  logic [NUM_PHASES-1:0] phaseEn,
  input  logic [NUM_PHASES-1:0] phaseTri,
  input  logic [VID_W-1:0]      vidTarget,
  input  logic [VID_W-1:0]      goalCode,
  output ctlStrobe_t            ctl,
  output logic [VID_W-1:0]      goalNext
);
  seqState_t        state, nextState;
  logic             inPs, goalPs, pendValid, psSet, psClr;
  logic [VID_W:0]   pendData, pick;
  logic             haveCmd, anyMove, shedFound, restFound;
  logic [SEL_W-1:0] shedIdx, restIdx;

  assign haveCmd  = cmdValid | pendValid;
  assign pick     = cmdValid ? cmdData : pendData;
  assign goalNext = pick[VID_W-1:0];
  assign anyMove  = |(phaseEn ^ ~phaseTri);

  always_comb begin
    shedFound = 1'b0;
    shedIdx   = '0;
    for (int i = BASE_PHASES; i < NUM_PHASES; i++)
      if (phaseEn[i]) begin
        shedFound = 1'b1;
        shedIdx   = SEL_W'(i);
      end
    restFound = 1'b0;
    restIdx   = '0;
    for (int i = NUM_PHASES - 1; i >= BASE_PHASES; i--)
      if (popMask[i] && !phaseEn[i]) begin
        restFound = 1'b1;
        restIdx   = SEL_W'(i);
      end
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    psSet     = 1'b0;
    psClr     = 1'b0;
    unique case (state)
      S_IDLE:
        if (haveCmd) begin
          ctl.loadGoal = 1'b1;
          nextState = (inPs && (pick[VID_W-1:0] != vidTarget || pick[VID_W])) ? S_RESTORE : S_STEP;
        end
      S_RESTORE:
        if (!anyMove) begin
          if (restFound) begin
            ctl.restore = 1'b1;
            ctl.sel     = restIdx;
          end else begin
            psClr     = 1'b1;
            nextState = S_STEP;
          end
        end
      S_STEP:
        if (vidTarget == goalCode) nextState = goalPs ? S_SHED : S_IDLE;
        else if (stepTick) begin
          ctl.stepUp = (goalCode > vidTarget);
          ctl.stepDn = (goalCode < vidTarget);
        end
      S_SHED:
        if (!anyMove) begin
          if (shedFound) begin
            ctl.shed = 1'b1;
            ctl.sel  = shedIdx;
          end else begin
            psSet     = 1'b1;
            nextState = S_IDLE;
          end
        end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      inPs      <= 1'b0;
      goalPs    <= 1'b0;
      pendValid <= 1'b0;
      pendData  <= '0;
    end else begin
      state <= nextState;
      if (psSet)      inPs <= 1'b1;
      else if (psClr) inPs <= 1'b0;
      if (ctl.loadGoal) goalPs <= ~pick[VID_W];
      if (cmdValid && state != S_IDLE) begin
        pendValid <= 1'b1;
        pendData  <= cmdData;
      end else if (state == S_IDLE && haveCmd) begin
        pendValid <= 1'b0;
      end
    end
  end

  // R2: at most one phase is between states at a time
  p_one_move_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(phaseEn ^ ~phaseTri));
  // R5: the target steps only while every populated phase is fully on
  p_step_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepUp || ctl.stepDn) |-> ((phaseEn & popMask) == popMask && (phaseTri & popMask) == '0));
endmodule

// File: rtl/phase_shed_seq.sv
module phase_shed_seq
  import phase_shed_pkg::*;
#(
  parameter int NUM_PHASES  = 4,
  parameter int BASE_PHASES = 2,
  parameter int VID_W       = 7,
  parameter int RESET_CODE  = 127,
  parameter int OFF_CODE    = 124,
  parameter int BASE_TENTH  = 15500,
  parameter int STEP_TENTH  = 125,
  parameter int LEVEL_W     = 14,
  localparam int CNT_W      = $clog2(NUM_PHASES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [VID_W:0]        cmdData,
  input  logic [CNT_W-1:0]      populated,
  input  logic [NUM_PHASES-1:0] pwmIn,
  input  logic                  stepTick,
  output logic [NUM_PHASES-1:0] phaseEn,
  output logic [NUM_PHASES-1:0] phaseTri,
  output logic [VID_W-1:0]      vidTarget,
  output logic                  targetDone,
  output logic                  outOff,
  output logic [LEVEL_W-1:0]    targetTenthMv
);
  ctlStrobe_t            ctl;
  logic [VID_W-1:0]      goalNext, goalCode;
  logic [NUM_PHASES-1:0] popMask;

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_pop
    assign popMask[i] = (i < BASE_PHASES) || (i < int'(populated));
  end

  phase_shed_ctl #(
    .NUM_PHASES(NUM_PHASES), .BASE_PHASES(BASE_PHASES), .VID_W(VID_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .stepTick(stepTick), .popMask(popMask), .phaseEn(phaseEn),
    .phaseTri(phaseTri), .vidTarget(vidTarget), .goalCode(goalCode),
    .ctl(ctl), .goalNext(goalNext)
  );

  phase_shed_dp #(
    .NUM_PHASES(NUM_PHASES), .BASE_PHASES(BASE_PHASES), .VID_W(VID_W),
    .RESET_CODE(RESET_CODE), .OFF_CODE(OFF_CODE), .BASE_TENTH(BASE_TENTH),
    .STEP_TENTH(STEP_TENTH), .LEVEL_W(LEVEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .goalIn(goalNext), .popMask(popMask),
    .pwmIn(pwmIn), .phaseEn(phaseEn), .phaseTri(phaseTri),
    .vidTarget(vidTarget), .goalCode(goalCode), .outOff(outOff),
    .targetTenthMv(targetTenthMv)
  );

  assign targetDone = (vidTarget == goalCode);

  // R8: a phase that is not populated is never enabled
  p_unpop_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phaseEn & ~popMask) == '0);
endmodule

// File: tb/phase_shed_seq_tb.sv
module phase_shed_seq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdData = '0;
  logic [2:0] populated = 3'd4;
  logic [3:0] pwmIn = '0;
  logic       stepTick = 1'b0;
  logic [3:0] phaseEn, phaseTri;
  logic [6:0] vidTarget;
  logic       targetDone, outOff;
  logic [13:0] targetTenthMv;

  int checks = 0, failures = 0;
  int enFallCnt = 0, enRiseCnt = 0, coincideCnt = 0;
  bit finished = 0;
  logic [3:0] lastEn = '0, lastTri = '0, lastPwm = '0;
  logic [2:0] lastPop = 3'd4;

  always #10 clk = ~clk;

  phase_shed_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .populated(populated), .pwmIn(pwmIn), .stepTick(stepTick),
    .phaseEn(phaseEn), .phaseTri(phaseTri), .vidTarget(vidTarget),
    .targetDone(targetDone), .outOff(outOff), .targetTenthMv(targetTenthMv)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] popBits(input logic [2:0] p);
    return (p >= 3'd4) ? 4'hF : (p == 3'd3) ? 4'h7 : 4'h3;
  endfunction

  // Monitor and PWM generator share one block so the PWM history is exact.
  always @(negedge clk) begin
    logic [3:0] pb;
    if (!rstN) begin
      pwmIn = '0;
      lastPwm = '0;
    end else begin
      pb = popBits(populated);
      for (int i = 0; i < 4; i++) begin
        if (lastEn[i] && !phaseEn[i] && lastPop == populated) begin
          enFallCnt++;
          check(!phaseTri[i], "R3 tri clear at enable drop", phaseTri[i], 0);
          if (pwmIn[i] && !lastPwm[i]) coincideCnt++;
          if (i == 2) check(phaseTri[3], "R2 phase4 tri before phase3 shed", phaseTri[3], 1);
        end
        if (!lastEn[i] && phaseEn[i] && lastPop == populated) begin
          enRiseCnt++;
          if (i == 3) check(phaseEn[2] && !phaseTri[2], "R4 phase3 on before phase4", {phaseEn[2], phaseTri[2]}, 2);
        end
        if (lastTri[i] != phaseTri[i] && lastPop == populated)
          check(pwmIn[i] && !lastPwm[i], "R3/R4 tri change on pwm rise", {lastPwm[i], pwmIn[i]}, 1);
      end
      if (lastEn == phaseEn && lastTri == phaseTri && vidTarget !== u_dut.vidTarget) ;
      lastPwm = pwmIn;
      pwmIn = ~pwmIn;
    end
    lastEn  = phaseEn;
    lastTri = phaseTri;
    lastPop = populated;
  end

  // R5: the target never moves while a populated phase is off or tri-stated
  logic [6:0] lastTgt = 7'd127;
  always @(negedge clk) begin
    logic [3:0] pb;
    if (rstN && vidTarget != lastTgt) begin
      pb = popBits(populated);
      check(((phaseEn & pb) == pb) && ((phaseTri & pb) == 4'h0), "R5 step with all phases on",
            {phaseEn, phaseTri}, {pb, 4'h0});
    end
    lastTgt = vidTarget;
  end

  task automatic sendCmd(input logic [7:0] b);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdData  = b;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectState(input string req, input logic [3:0] en, input logic [3:0] tri_, input int code);
    check(phaseEn == en, {req, " phaseEn"}, phaseEn, en);
    check(phaseTri == tri_, {req, " phaseTri"}, phaseTri, tri_);
    check(vidTarget == 7'(code), {req, " vidTarget"}, vidTarget, code);
    check(targetDone, {req, " targetDone"}, targetDone, 1);
  endtask

  task automatic testReset();
    check(phaseEn == 4'hF && phaseTri == 4'h0, "R10 reset phases", {phaseEn, phaseTri}, 8'hF0);
    check(vidTarget == 7'd127 && targetDone, "R10 reset target", vidTarget, 127);
    check(outOff && targetTenthMv == 0, "R7 reset code off", targetTenthMv, 0);
  endtask

  task automatic testStepping();
    stepTick = 1'b0;
    sendCmd(8'h80 | 8'd20);
    settle(10);
    check(vidTarget == 7'd127 && !targetDone, "R6 no tick no move", vidTarget, 127);
    repeat (3) begin
      @(negedge clk); stepTick = 1'b1;
      @(negedge clk); stepTick = 1'b0;
    end
    settle(2);
    check(vidTarget == 7'd124, "R6 three ticks three codes", vidTarget, 124);
    check(outOff && targetTenthMv == 0, "R7 code 124 is off", outOff, 1);
    @(negedge clk); stepTick = 1'b1;
    @(negedge clk); stepTick = 1'b0;
    settle(2);
    check(!outOff && targetTenthMv == 14'd125, "R7 code 123 level", targetTenthMv, 125);
    stepTick = 1'b1;
    settle(300);
    expectState("R1 normal cmd", 4'hF, 4'h0, 20);
    check(!outOff && targetTenthMv == 14'd13000, "R7 code 20 level", targetTenthMv, 13000);
  endtask

  task automatic shedAtParity(input bit parity, input int code);
    @(posedge clk);
    while (pwmIn[3] != parity) @(posedge clk);
    enFallCnt = 0;
    sendCmd(8'(code));
    settle(300);
    expectState("R2 power saving", 4'h3, 4'hC, code);
    check(enFallCnt == 2, "R2 two phases shed", enFallCnt, 2);
  endtask

  task automatic testExitRestore(input int code);
    enRiseCnt = 0;
    sendCmd(8'h80 | 8'(code));
    settle(300);
    expectState("R4 exit power saving", 4'hF, 4'h0, code);
    check(enRiseCnt == 2, "R4 two phases restored", enRiseCnt, 2);
  endtask

  task automatic testCoincidence();
    coincideCnt = 0;
    shedAtParity(1'b0, 20);
    testExitRestore(20);
    shedAtParity(1'b1, 20);
    check(coincideCnt >= 1, "R3 edge coincided with enable drop", coincideCnt, 1);
  endtask

  task automatic testChangeInPs();
    enFallCnt = 0;
    enRiseCnt = 0;
    sendCmd(8'd40);
    settle(300);
    expectState("R5 change under power saving", 4'h3, 4'hC, 40);
    check(enRiseCnt == 2 && enFallCnt == 2, "R5 restore then shed", enRiseCnt * 10 + enFallCnt, 22);
    check(targetTenthMv == 14'd10500, "R7 code 40 level", targetTenthMv, 10500);
  endtask

  task automatic testPending();
    testExitRestore(40);
    stepTick = 1'b0;
    enFallCnt = 0;
    sendCmd(8'h80 | 8'd60);
    sendCmd(8'd60);
    sendCmd(8'h80 | 8'd80);
    settle(20);
    check(vidTarget == 7'd40 && !targetDone, "R9 busy holds target", vidTarget, 40);
    stepTick = 1'b1;
    settle(300);
    expectState("R9 latest pending wins", 4'hF, 4'h0, 80);
    check(enFallCnt == 0, "R9 replaced command dropped", enFallCnt, 0);
    check(targetTenthMv == 14'd5500, "R7 code 80 level", targetTenthMv, 5500);
  endtask

  task automatic testPopulated();
    @(negedge clk);
    populated = 3'd3;
    settle(2);
    check(phaseEn == 4'h7 && phaseTri == 4'h8, "R8 three populated", {phaseEn, phaseTri}, 8'h78);
    enFallCnt = 0;
    sendCmd(8'd80);
    settle(300);
    expectState("R8 shed with three", 4'h3, 4'hC, 80);
    check(enFallCnt == 1, "R8 only phase3 shed", enFallCnt, 1);
    @(negedge clk);
    populated = 3'd2;
    enRiseCnt = 0;
    settle(2);
    sendCmd(8'h80 | 8'd80);
    settle(300);
    expectState("R8 two populated exit", 4'h3, 4'hC, 80);
    check(enRiseCnt == 0, "R8 unpopulated not restored", enRiseCnt, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    settle(2);
    testReset();
    testStepping();
    testCoincidence();
    testChangeInPs();
    testPending();
    testPopulated();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule